// File: doc/BRIEF.md
# Fixed-Point ALU with Status Flags

A 16-bit two's-complement arithmetic and logic unit for a signal-processing datapath. Each cycle with `opValid` high it takes an X and a Y operand, an operation code, a destination select and a condition code. If the condition holds against the flags currently stored, it computes the result. It writes the result either to the main result register (`resOut`) or to the feedback register (`fbOut`), and updates the stored status flags. The carry-in of the carry and borrow operations is the stored carry flag.

Two mode inputs change how results are kept. `satMode` clamps overflowing arithmetic results that go to the main result register to the largest positive or largest negative value. `ovLatchMode` makes the overflow flag sticky until `clrOv` clears it. All outputs are registered: an operation issued in one cycle is visible after the next rising clock edge.

Top module: `dsp_alu16`

## Requirements
- R1: Adder operations, by `opCode`: 0 X+Y, 1 X+Y+C, 2 X−Y, 3 X−Y+C−1, 4 Y−X, 5 Y−X+C−1, 13 −X, 14 −Y, 15 ABS X, 16 Y+1, 17 Y−1, 11 PASS X, 12 PASS Y. C is the stored carry flag. Results wrap modulo 2^16.
- R2: Logical operations: 6 X AND Y, 7 X OR Y, 8 X XOR Y, 9 NOT X, 10 NOT Y.
- R3: Bit operations on bit `bitSel` (0..15) of X: 18 test (X AND mask), 19 set, 20 clear, 21 toggle.
- R4: With `destFb`=0 only `resOut` is written; with `destFb`=1 only `fbOut` is written.
- R5: `zeroFlag` is set when the unsaturated result is zero, and `negFlag` copies its bit 15.
- R6: For adder operations, `carryFlag` is the carry out of bit 15. `ovfFlag` is the XOR of the carries out of bits 15 and 14. Subtraction is done as addition of the inverted operand, so carry=1 means no borrow. Logical and bit operations clear both flags.
- R7: `signFlag` takes bit 15 of X on ABS (15) and keeps its value on every other operation.
- R8: With `satMode`=1 and `destFb`=0, an overflowing adder result is written as 0x7FFF if carry=0 and as 0x8000 if carry=1. Without overflow the raw result is written. Flags always come from the raw result.
- R9: Results written to the feedback register are never saturated.
- R10: With `ovLatchMode`=1 a set `ovfFlag` stays set until `clrOv`. A `clrOv` in the same cycle as an overflowing operation leaves the flag set. Without latch mode, each operation rewrites the flag.
- R11: `condCode`: 0 always, 1 EQ (Z), 2 NE, 3 LT (N xor V), 4 GE, 5 LE (LT or Z), 6 GT, 7 V, 8 not V, 9 C, 10 not C; codes 11..15 are never true. If the condition is false, neither register nor any flag changes.
- R12: Reset clears both registers and all flags. Opcodes 22..31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Issue an operation this cycle |
| opCode | input | 5 | Operation code |
| bitSel | input | 4 | Bit index for bit operations |
| xIn | input | 16 | X operand |
| yIn | input | 16 | Y operand |
| destFb | input | 1 | 1 = feedback register, 0 = main result register |
| condCode | input | 4 | Condition code |
| satMode | input | 1 | Saturate main-register results on overflow |
| ovLatchMode | input | 1 | Sticky overflow flag |
| clrOv | input | 1 | Clear the overflow flag |
| resOut | output | 16 | Main result register |
| fbOut | output | 16 | Feedback register |
| zeroFlag | output | 1 | Zero flag |
| negFlag | output | 1 | Negative flag |
| ovfFlag | output | 1 | Overflow flag |
| carryFlag | output | 1 | Carry flag |
| signFlag | output | 1 | X-sign flag from ABS |

## Verification
Two functions can fall in the same cycle: an explicit overflow clear and a new overflow in latch mode. The bench issues `clrOv` together with an overflowing add and expects the flag to stay set. A plain `clrOv` with no operation must drop it. Saturation and flag update also coincide. The bench overflows into the main register with saturation on and expects the clamped value in `resOut`, while the flags describe the raw sum. The same add sent to the feedback register must land unclamped.

// File: rtl/dsp_alu_pkg.sv
package dsp_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD = 5'd0, OP_ADC = 5'd1, OP_SUB = 5'd2, OP_SBB = 5'd3,
    OP_RSUB = 5'd4, OP_RSBB = 5'd5, OP_AND = 5'd6, OP_OR = 5'd7,
    OP_XOR = 5'd8, OP_NOTX = 5'd9, OP_NOTY = 5'd10, OP_PASSX = 5'd11,
    OP_PASSY = 5'd12, OP_NEGX = 5'd13, OP_NEGY = 5'd14, OP_ABSX = 5'd15,
    OP_INCY = 5'd16, OP_DECY = 5'd17, OP_TST = 5'd18, OP_SET = 5'd19,
    OP_CLR = 5'd20, OP_TGL = 5'd21
  } aluOp_e;

  typedef enum logic [3:0] {
    CC_ALWAYS = 4'd0, CC_EQ = 4'd1, CC_NE = 4'd2, CC_LT = 4'd3,
    CC_GE = 4'd4, CC_LE = 4'd5, CC_GT = 4'd6, CC_AV = 4'd7,
    CC_NAV = 4'd8, CC_AC = 4'd9, CC_NAC = 4'd10
  } cond_e;

  // strobes from control to datapath
  typedef struct packed {
    logic exec;
    logic wrRes;
    logic wrFb;
    logic updSign;
    logic clrOv;
  } aluStrobe_t;
endpackage

// File: rtl/dsp_alu_ctrl.sv
module dsp_alu_ctrl
  import dsp_alu_pkg::*;
(
  input  logic       opValid,
  input  logic [4:0] opCode,
  input  logic [3:0] condCode,
  input  logic       destFb,
  input  logic       clrOv,
  input  logic       zf,
  input  logic       nf,
  input  logic       vf,
  input  logic       cf,
  output aluStrobe_t strobe
);
  logic condTrue;
  logic opLegal;
  logic lessThan;

  assign lessThan = nf ^ vf;
  assign opLegal  = (opCode <= OP_TGL);

  // R11 condition evaluation against stored flags
  always_comb begin
    case (condCode)
      CC_ALWAYS: condTrue = 1'b1;
      CC_EQ:     condTrue = zf;
      CC_NE:     condTrue = !zf;
      CC_LT:     condTrue = lessThan;
      CC_GE:     condTrue = !lessThan;
      CC_LE:     condTrue = lessThan | zf;
      CC_GT:     condTrue = !(lessThan | zf);
      CC_AV:     condTrue = vf;
      CC_NAV:    condTrue = !vf;
      CC_AC:     condTrue = cf;
      CC_NAC:    condTrue = !cf;
      default:   condTrue = 1'b0;
    endcase
  end

  always_comb begin
    strobe.exec    = opValid & condTrue & opLegal;
    strobe.wrRes   = strobe.exec & !destFb;
    strobe.wrFb    = strobe.exec & destFb;
    strobe.updSign = strobe.exec & (opCode == OP_ABSX);
    strobe.clrOv   = clrOv;
  end
endmodule

// File: rtl/dsp_alu_dp.sv
module dsp_alu_dp
  import dsp_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [4:0]    opCode,
  input  logic [BW-1:0] bitSel,
  input  logic [W-1:0]  xIn,
  input  logic [W-1:0]  yIn,
  input  logic          satMode,
  input  logic          ovLatchMode,
  input  aluStrobe_t    strobe,
  output logic [W-1:0]  resOut,
  output logic [W-1:0]  fbOut,
  output logic          zf,
  output logic          nf,
  output logic          vf,
  output logic          cf,
  output logic          sf
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MAX_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] opA, opB, logicRes, bitMask, lowSum, rawRes, resVal;
  logic [1:0]   topSum;
  logic         cin, isLogic, carryTop, carryNext, newC, newV;

  assign bitMask = {{(W-1){1'b0}}, 1'b1} << bitSel;

  // operand steering onto the single adder
  always_comb begin
    opA = '0; opB = '0; cin = 1'b0; isLogic = 1'b0; logicRes = '0;
    case (opCode)
      OP_ADD:   begin opA = xIn; opB = yIn; end
      OP_ADC:   begin opA = xIn; opB = yIn; cin = cf; end
      OP_SUB:   begin opA = xIn; opB = ~yIn; cin = 1'b1; end
      OP_SBB:   begin opA = xIn; opB = ~yIn; cin = cf; end
      OP_RSUB:  begin opA = yIn; opB = ~xIn; cin = 1'b1; end
      OP_RSBB:  begin opA = yIn; opB = ~xIn; cin = cf; end
      OP_AND:   begin isLogic = 1'b1; logicRes = xIn & yIn; end
      OP_OR:    begin isLogic = 1'b1; logicRes = xIn | yIn; end
      OP_XOR:   begin isLogic = 1'b1; logicRes = xIn ^ yIn; end
      OP_NOTX:  begin isLogic = 1'b1; logicRes = ~xIn; end
      OP_NOTY:  begin isLogic = 1'b1; logicRes = ~yIn; end
      OP_PASSX: opA = xIn;
      OP_PASSY: opA = yIn;
      OP_NEGX:  begin opB = ~xIn; cin = 1'b1; end
      OP_NEGY:  begin opB = ~yIn; cin = 1'b1; end
      OP_ABSX:  begin
        if (xIn[W-1]) begin opB = ~xIn; cin = 1'b1; end
        else opA = xIn;
      end
      OP_INCY:  begin opA = yIn; cin = 1'b1; end
      OP_DECY:  begin opA = yIn; opB = '1; end
      OP_TST:   begin isLogic = 1'b1; logicRes = xIn & bitMask; end
      OP_SET:   begin isLogic = 1'b1; logicRes = xIn | bitMask; end
      OP_CLR:   begin isLogic = 1'b1; logicRes = xIn & ~bitMask; end
      OP_TGL:   begin isLogic = 1'b1; logicRes = xIn ^ bitMask; end
      default:  ;
    endcase
  end

  // adder split so both top carries are visible (R6)
  always_comb begin
    lowSum    = {1'b0, opA[W-2:0]} + {1'b0, opB[W-2:0]} + {{(W-1){1'b0}}, cin};
    carryNext = lowSum[W-1];
    topSum    = {1'b0, opA[W-1]} + {1'b0, opB[W-1]} + {1'b0, carryNext};
    carryTop  = topSum[1];
    rawRes    = isLogic ? logicRes : {topSum[0], lowSum[W-2:0]};
    newC      = isLogic ? 1'b0 : carryTop;
    newV      = isLogic ? 1'b0 : (carryTop ^ carryNext);
    // R8 saturation picks its value from the carry
    if (satMode && newV) resVal = carryTop ? MAX_NEG : MAX_POS;
    else                 resVal = rawRes;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resOut <= '0; fbOut <= '0;
      zf <= 1'b0; nf <= 1'b0; vf <= 1'b0; cf <= 1'b0; sf <= 1'b0;
    end else begin
      if (strobe.wrRes) resOut <= resVal;
      if (strobe.wrFb)  fbOut  <= rawRes;
      if (strobe.updSign) sf <= xIn[W-1];
      if (strobe.exec) begin
        zf <= (rawRes == '0);
        nf <= rawRes[W-1];
        cf <= newC;
        vf <= ((ovLatchMode && !strobe.clrOv) ? vf : 1'b0) | newV;
      end else if (strobe.clrOv) begin
        vf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dsp_alu16.sv
module dsp_alu16
  import dsp_alu_pkg::*;
#(
  parameter int W  = 16,
  parameter int BW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          opValid,
  input  logic [4:0]    opCode,
  input  logic [BW-1:0] bitSel,
  input  logic [W-1:0]  xIn,
  input  logic [W-1:0]  yIn,
  input  logic          destFb,
  input  logic [3:0]    condCode,
  input  logic          satMode,
  input  logic          ovLatchMode,
  input  logic          clrOv,
  output logic [W-1:0]  resOut,
  output logic [W-1:0]  fbOut,
  output logic          zeroFlag,
  output logic          negFlag,
  output logic          ovfFlag,
  output logic          carryFlag,
  output logic          signFlag
);
  aluStrobe_t strobe;

  dsp_alu_ctrl u_ctrl (
    .opValid(opValid), .opCode(opCode), .condCode(condCode),
    .destFb(destFb), .clrOv(clrOv),
    .zf(zeroFlag), .nf(negFlag), .vf(ovfFlag), .cf(carryFlag),
    .strobe(strobe)
  );

  dsp_alu_dp #(.W(W), .BW(BW)) u_dp (
    .clk(clk), .rstN(rstN), .opCode(opCode), .bitSel(bitSel),
    .xIn(xIn), .yIn(yIn), .satMode(satMode), .ovLatchMode(ovLatchMode),
    .strobe(strobe), .resOut(resOut), .fbOut(fbOut),
    .zf(zeroFlag), .nf(negFlag), .vf(ovfFlag), .cf(carryFlag), .sf(signFlag)
  );
endmodule

// File: rtl/dsp_alu16_chk.sv
module dsp_alu16_chk #(
  parameter int W  = 16,
  parameter int BW = $clog2(W)
) (
  input logic          clk,
  input logic          rstN,
  input logic          opValid,
  input logic [4:0]    opCode,
  input logic [BW-1:0] bitSel,
  input logic [W-1:0]  xIn,
  input logic [W-1:0]  yIn,
  input logic          destFb,
  input logic [3:0]    condCode,
  input logic          satMode,
  input logic          ovLatchMode,
  input logic          clrOv,
  input logic [W-1:0]  resOut,
  input logic [W-1:0]  fbOut,
  input logic          zeroFlag,
  input logic          negFlag,
  input logic          ovfFlag,
  input logic          carryFlag,
  input logic          signFlag
);
  logic alwaysIssue;
  logic isLogicOp;
  logic [W:0] posSum;

  assign alwaysIssue = opValid && (condCode == 4'd0) && (opCode <= 5'd21);
  assign isLogicOp   = (opCode >= 5'd6 && opCode <= 5'd10) || (opCode >= 5'd18 && opCode <= 5'd21);
  assign posSum      = {1'b0, xIn} + {1'b0, yIn};

  p_fb_keeps_res_r4: assert property (@(posedge clk) disable iff (!rstN)
    alwaysIssue && destFb |=> $stable(resOut));

  p_flags_track_res_r5: assert property (@(posedge clk) disable iff (!rstN)
    alwaysIssue && !destFb && !satMode |=> (negFlag == resOut[W-1]) && (zeroFlag == (resOut == '0)));

  p_logic_clears_carry_r6: assert property (@(posedge clk) disable iff (!rstN)
    alwaysIssue && isLogicOp |=> !carryFlag && ($past(ovLatchMode) || !ovfFlag));

  p_sign_only_abs_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(opValid && opCode == 5'd15) |=> $stable(signFlag));

  p_sat_positive_r8: assert property (@(posedge clk) disable iff (!rstN)
    alwaysIssue && satMode && !destFb && opCode == 5'd0 && !xIn[W-1] && !yIn[W-1]
      && posSum[W-1] |=> resOut == {1'b0, {(W-1){1'b1}}});

  p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovLatchMode && ovfFlag && !clrOv |=> ovfFlag);

  p_false_cond_holds_r11: assert property (@(posedge clk) disable iff (!rstN)
    opValid && condCode == 4'd1 && !zeroFlag && !clrOv |=>
      $stable(resOut) && $stable(fbOut) &&
      $stable({zeroFlag, negFlag, ovfFlag, carryFlag, signFlag}));
endmodule

bind dsp_alu16 dsp_alu16_chk #(.W(W), .BW(BW)) u_chk (
  .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .bitSel(bitSel),
  .xIn(xIn), .yIn(yIn), .destFb(destFb), .condCode(condCode), .satMode(satMode),
  .ovLatchMode(ovLatchMode), .clrOv(clrOv), .resOut(resOut), .fbOut(fbOut),
  .zeroFlag(zeroFlag), .negFlag(negFlag), .ovfFlag(ovfFlag),
  .carryFlag(carryFlag), .signFlag(signFlag)
);

// File: tb/sim_dsp_alu16.sv
`timescale 1ns/1ps
module sim_dsp_alu16;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic [3:0] bitSel = '0;
  logic [15:0] xIn = '0, yIn = '0;
  logic destFb = 1'b0;
  logic [3:0] condCode = '0;
  logic satMode = 1'b0, ovLatchMode = 1'b0, clrOv = 1'b0;
  logic [15:0] resOut, fbOut;
  logic zeroFlag, negFlag, ovfFlag, carryFlag, signFlag;
  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  dsp_alu16 u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .bitSel(bitSel),
    .xIn(xIn), .yIn(yIn), .destFb(destFb), .condCode(condCode), .satMode(satMode),
    .ovLatchMode(ovLatchMode), .clrOv(clrOv), .resOut(resOut), .fbOut(fbOut),
    .zeroFlag(zeroFlag), .negFlag(negFlag), .ovfFlag(ovfFlag),
    .carryFlag(carryFlag), .signFlag(signFlag)
  );

  // vector: op(5) bit(4) x(16) y(16) res(16) flags{z,n,v,c,s}(5)
  localparam int NV = 25;
  localparam logic [61:0] VEC [NV] = '{
    {5'd0,  4'd0,  16'h1234, 16'h0001, 16'h1235, 5'b00000},
    {5'd0,  4'd0,  16'h7FFF, 16'h0001, 16'h8000, 5'b01100},
    {5'd0,  4'd0,  16'hFFFF, 16'h0001, 16'h0000, 5'b10010},
    {5'd1,  4'd0,  16'h0010, 16'h0020, 16'h0031, 5'b00000},
    {5'd2,  4'd0,  16'h0005, 16'h0007, 16'hFFFE, 5'b01000},
    {5'd3,  4'd0,  16'h0010, 16'h0003, 16'h000C, 5'b00010},
    {5'd5,  4'd0,  16'h0003, 16'h0010, 16'h000D, 5'b00010},
    {5'd4,  4'd0,  16'h0001, 16'h8000, 16'h7FFF, 5'b00110},
    {5'd6,  4'd0,  16'hF0F0, 16'h0FF0, 16'h00F0, 5'b00000},
    {5'd8,  4'd0,  16'hAAAA, 16'hAAAA, 16'h0000, 5'b10000},
    {5'd10, 4'd0,  16'h0000, 16'h00FF, 16'hFF00, 5'b01000},
    {5'd13, 4'd0,  16'h8000, 16'h0000, 16'h8000, 5'b01100},
    {5'd15, 4'd0,  16'hFFFB, 16'h0000, 16'h0005, 5'b00001},
    {5'd16, 4'd0,  16'h0000, 16'h7FFF, 16'h8000, 5'b01101},
    {5'd17, 4'd0,  16'h0000, 16'h0000, 16'hFFFF, 5'b01001},
    {5'd15, 4'd0,  16'h0004, 16'h0000, 16'h0004, 5'b00000},
    {5'd21, 4'd15, 16'h0001, 16'h0000, 16'h8001, 5'b01000},
    {5'd18, 4'd2,  16'h0008, 16'h0000, 16'h0000, 5'b10000},
    {5'd18, 4'd3,  16'h0008, 16'h0000, 16'h0008, 5'b00000},
    {5'd20, 4'd0,  16'hFFFF, 16'h0000, 16'hFFFE, 5'b01000},
    {5'd11, 4'd0,  16'h0000, 16'h1111, 16'h0000, 5'b10000},
    {5'd7,  4'd0,  16'h1200, 16'h0034, 16'h1234, 5'b00000},
    {5'd19, 4'd4,  16'h0000, 16'h0000, 16'h0010, 5'b00000},
    {5'd14, 4'd0,  16'h0000, 16'h0001, 16'hFFFF, 5'b01000},
    {5'd9,  4'd0,  16'h0000, 16'h0000, 16'hFFFF, 5'b01000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] flagsNow();
    return {11'd0, zeroFlag, negFlag, ovfFlag, carryFlag, signFlag};
  endfunction

  task automatic issue(input logic [4:0] op, input logic [3:0] bsel,
                       input logic [15:0] x, input logic [15:0] y,
                       input logic [3:0] cc, input logic fb, input logic clr);
    @(negedge clk);
    opValid = 1'b1; opCode = op; bitSel = bsel; xIn = x; yIn = y;
    condCode = cc; destFb = fb; clrOv = clr;
    @(negedge clk);
    opValid = 1'b0; clrOv = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 reset res", resOut, 16'h0000);
    check("R12 reset fb", fbOut, 16'h0000);
    check("R12 reset flags", flagsNow(), 16'h0000);
    rstN = 1'b1;

    // R1 R2 R3 R5 R6 R7 table walk
    for (int i = 0; i < NV; i++) begin
      issue(VEC[i][61:57], VEC[i][56:53], VEC[i][52:37], VEC[i][36:21], 4'd0, 1'b0, 1'b0);
      check($sformatf("R1/R2/R3 result vec %0d", i), resOut, VEC[i][20:5]);
      check($sformatf("R5/R6/R7 flags vec %0d", i), flagsNow(), {11'd0, VEC[i][4:0]});
    end

    // R4 feedback destination leaves resOut alone
    issue(5'd0, 4'd0, 16'h0100, 16'h0023, 4'd0, 1'b1, 1'b0);
    check("R4 fb written", fbOut, 16'h0123);
    check("R4 res untouched", resOut, 16'hFFFF);

    // R8 saturation to the main register
    satMode = 1'b1;
    issue(5'd0, 4'd0, 16'h7FFF, 16'h0001, 4'd0, 1'b0, 1'b0);
    check("R8 sat positive", resOut, 16'h7FFF);
    check("R8 raw flags", flagsNow(), {11'd0, 5'b01100});
    issue(5'd0, 4'd0, 16'h8000, 16'h8000, 4'd0, 1'b0, 1'b0);
    check("R8 sat negative", resOut, 16'h8000);
    check("R8 raw zero flag", flagsNow(), {11'd0, 5'b10110});
    issue(5'd0, 4'd0, 16'h0002, 16'h0003, 4'd0, 1'b0, 1'b0);
    check("R8 no overflow raw kept", resOut, 16'h0005);
    // R9 feedback never saturates
    issue(5'd0, 4'd0, 16'h7FFF, 16'h0001, 4'd0, 1'b1, 1'b0);
    check("R9 fb raw", fbOut, 16'h8000);
    check("R9 res untouched", resOut, 16'h0005);
    satMode = 1'b0;

    // R10 sticky overflow
    ovLatchMode = 1'b1;
    issue(5'd0, 4'd0, 16'h7FFF, 16'h0001, 4'd0, 1'b0, 1'b0);
    issue(5'd0, 4'd0, 16'h0001, 16'h0001, 4'd0, 1'b0, 1'b0);
    check("R10 sticky held", {15'd0, ovfFlag}, 16'd1);
    check("R10 sticky result", resOut, 16'h0002);
    issue(5'd25, 4'd0, 16'h0000, 16'h0000, 4'd0, 1'b0, 1'b1);
    check("R10 clear", {15'd0, ovfFlag}, 16'd0);
    issue(5'd0, 4'd0, 16'h7FFF, 16'h0001, 4'd0, 1'b0, 1'b1);
    check("R10 clear with new overflow", {15'd0, ovfFlag}, 16'd1);
    ovLatchMode = 1'b0;
    issue(5'd0, 4'd0, 16'h0001, 16'h0001, 4'd0, 1'b0, 1'b0);
    check("R10 non-sticky rewrite", {15'd0, ovfFlag}, 16'd0);

    // R11 conditions
    issue(5'd0, 4'd0, 16'hFFFF, 16'h0000, 4'd0, 1'b0, 1'b0); // N=1 Z=0 V=0 C=0
    issue(5'd0, 4'd0, 16'h0001, 16'h0001, 4'd1, 1'b0, 1'b0); // EQ false
    check("R11 EQ false res", resOut, 16'hFFFF);
    check("R11 EQ false flags", flagsNow(), {11'd0, 5'b01000});
    issue(5'd0, 4'd0, 16'h0001, 16'h0001, 4'd3, 1'b0, 1'b0); // LT true
    check("R11 LT true", resOut, 16'h0002);
    issue(5'd11, 4'd0, 16'h0000, 16'h0000, 4'd6, 1'b0, 1'b0); // GT true
    check("R11 GT true", resOut, 16'h0000);
    issue(5'd11, 4'd0, 16'h0005, 16'h0000, 4'd2, 1'b0, 1'b0); // NE false (Z=1)
    check("R11 NE false", resOut, 16'h0000);
    issue(5'd11, 4'd0, 16'h0006, 16'h0000, 4'd9, 1'b0, 1'b0); // AC false
    check("R11 AC false", resOut, 16'h0000);
    issue(5'd11, 4'd0, 16'h0007, 16'h0000, 4'd10, 1'b0, 1'b0); // NAC true
    check("R11 NAC true", resOut, 16'h0007);
    issue(5'd11, 4'd0, 16'h0009, 16'h0000, 4'd12, 1'b0, 1'b0); // code 12 never
    check("R11 code 12 never", resOut, 16'h0007);

    // R12 unused opcode
    issue(5'd28, 4'd0, 16'h5555, 16'h5555, 4'd0, 1'b0, 1'b0);
    check("R12 unused op res", resOut, 16'h0007);
    check("R12 unused op flags", flagsNow(), {11'd0, 5'b00000});

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule